// File: doc/BRIEF.md
# Serial Peripheral Word Master with Parity-Shaped Clock Divider

This block moves one word at a time over a four-wire serial peripheral link as the bus master. Software or a neighbouring engine presents a word, a length and a divide setting, then pulses `start`. The block pulls the active-low select line down and waits one whole serial period. It then toggles the serial clock, shifting the word out most-significant bit first while it collects the same number of bits from the slave.

The serial clock is derived from the system clock. A serial period lasts `max(div,1) + 1` system clocks. The split between the high and low phases depends on whether the divide value is odd or even. For odd values the two phases are equal. For even values the high phase is one clock longer than the low phase. Transmit data moves only when the clock falls, and receive data is captured when the clock rises. The clock rests low whenever the select line is high.

When the transfer ends, the select line returns high, the transmit driver enable drops and a one-cycle `done` strobe presents the received word. A new `start` is accepted in that same cycle.

Top module: `spi_word_master`

## Requirements
- R1: `start` is acted on only while `busy` is low. `busy` is high from the cycle after an accepted start until `ss_n` returns high. A start while busy changes neither the word on `mosi` nor the timing of the transfer in progress.
- R2: `ss_n` falls in the cycle after an accepted start. It stays low for exactly one serial period before the first rising edge of `sclk`.
- R3: Consecutive rising edges of `sclk` are `P = max(div,1) + 1` system clocks apart. A `div` of 0 behaves as a `div` of 1. `div` is latched at start.
- R4: The high phase of `sclk` lasts `P/2` clocks when `max(div,1)` is odd, and `max(div,1)/2 + 1` clocks when it is even. The low phase takes the rest of `P`.
- R5: `sclk` is low whenever `ss_n` is high, and it only rises while `ss_n` is low.
- R6: `mosi` carries the word from bit `len-1` down to bit 0. The first bit appears when `ss_n` falls, and each later bit appears in the cycle `sclk` falls. `tx_word` bits at or above `len` are not sent.
- R7: `miso` is captured at every rising `sclk` edge, first bit into the most significant position of the word. `rx_word` holds the word in bits `len-1..0`, with zeros above.
- R8: After the last rising edge, `sclk` stays high for one high phase. Then `sclk` falls and `ss_n` rises in the same cycle. `mosi_oe` is high exactly while `ss_n` is low, and `mosi` reads 0 when it is low.
- R9: `done` is high for exactly one cycle, the cycle in which `ss_n` rises. `rx_word` is valid from that cycle on.
- R10: The effective length is `word_len` clamped to the range 4..MAX_BITS. It is latched at start.
- R11: A start presented in the `done` cycle is accepted, so `ss_n` is high for exactly one cycle between the two transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer (honoured only while idle) |
| tx_word | input | MAX_BITS | Word to transmit, right-aligned |
| word_len | input | LEN_W | Requested bits per word |
| div | input | DIV_W | Serial clock divide setting |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer strobe |
| rx_word | output | MAX_BITS | Received word, right-aligned |
| sclk | output | 1 | Serial clock, idle low |
| ss_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for `mosi`; low means released |
| miso | input | 1 | Serial data in |

## Verification
The end of one transfer and the acceptance of the next can fall in the same cycle. In that cycle `done` pulses and `ss_n` rises while the idle check sees a fresh `start`. The bench provokes this by raising `start` with a new word and new settings in exactly the cycle it observes `done`. It then judges that `ss_n` stayed high for a single cycle, that the first word was received intact, and that the second transfer keeps its own period, phase split and data. A start injected in the middle of a transfer is also judged, by the transmitted bits and the edge spacing staying unchanged.

// File: rtl/spi_mst_pkg.sv
// Shared types for the serial word master.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package spi_mst_pkg;
    // Controller phases: idle, select lead-in, clock high, clock low
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_HIGH = 2'd2,
        ST_LOW  = 2'd3
    } spi_state_e;
endpackage

// File: rtl/spi_phase_calc.sv
// Turns a divide setting into serial period, high-phase and low-phase
// lengths in system clocks. Purely combinational.
// Assumes: a divide of 0 is treated as 1 so every phase lasts at least one clock.
module spi_phase_calc #(
    parameter int DIV_W = 8,
    localparam int CNT_W = DIV_W + 1
) (
    input  logic [DIV_W-1:0] div,
    output logic [CNT_W-1:0] period_len,
    output logic [CNT_W-1:0] high_len,
    output logic [CNT_W-1:0] low_len
);
    logic [CNT_W-1:0] div_eff;

    // Derive the phase lengths: odd divide splits evenly, even divide favours high
    always_comb begin
        div_eff    = (div == '0) ? CNT_W'(1) : {1'b0, div};
        period_len = div_eff + CNT_W'(1);
        if (div_eff[0])
            high_len = period_len >> 1;
        else
            high_len = (div_eff >> 1) + CNT_W'(1);
        low_len = period_len - high_len;
    end

    // R4: high phase never shorter than low, and at most one clock longer
    always_comb begin
        p_phase_split_r4: assert (high_len >= low_len && (high_len - low_len) <= CNT_W'(1));
    end
endmodule

// File: rtl/spi_shift_unit.sv
// Transmit and receive shift registers. The transmit word is left-aligned
// on load so that its bit len-1 sits at the output. It advances on each
// clock-fall event. Receive bits enter at the bottom on each clock-rise event.
// Assumes: len is already clamped to 4..MAX_BITS by the caller.
module spi_shift_unit #(
    parameter int MAX_BITS = 32,
    parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [MAX_BITS-1:0] tx_word,
    input  logic [LEN_W-1:0]    len,
    input  logic                shift_ev,
    input  logic                sample_ev,
    input  logic                miso,
    output logic                mosi_bit,
    output logic [MAX_BITS-1:0] rx_bits
);
    logic [MAX_BITS-1:0] tx_sh;

    // Transmit register: align the word on load, move one bit up per fall
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_sh <= '0;
        else if (load)
            tx_sh <= tx_word << (MAX_BITS - int'(len));
        else if (shift_ev)
            tx_sh <= tx_sh << 1;
    end

    // Receive register: clear on load, append the line value on each rise
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_bits <= '0;
        else if (load)
            rx_bits <= '0;
        else if (sample_ev)
            rx_bits <= {rx_bits[MAX_BITS-2:0], miso};
    end

    assign mosi_bit = tx_sh[MAX_BITS-1];

    // R6: shifting and sampling are never requested together with a load
    p_no_load_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !(shift_ev || sample_ev));
endmodule

// File: rtl/spi_word_master.sv
// Serial peripheral master for one word per start. It sequences select
// lead-in, clock high and low phases and the end of transfer, and drives the
// pins from registers.
// Assumes: synchronous active-low reset; miso is stable around each rising sclk.
module spi_word_master #(
    parameter int MAX_BITS = 32,
    parameter int DIV_W    = 8,
    parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [MAX_BITS-1:0] tx_word,
    input  logic [LEN_W-1:0]    word_len,
    input  logic [DIV_W-1:0]    div,
    output logic                busy,
    output logic                done,
    output logic [MAX_BITS-1:0] rx_word,
    output logic                sclk,
    output logic                ss_n,
    output logic                mosi,
    output logic                mosi_oe,
    input  logic                miso
);
    import spi_mst_pkg::*;

    localparam int MIN_BITS = 4;
    localparam int CNT_W    = DIV_W + 1;

    spi_state_e          state;
    logic [CNT_W-1:0]    cnt;
    logic [CNT_W-1:0]    per_len, hi_len, lo_len;
    logic [DIV_W-1:0]    div_q, div_sel;
    logic [LEN_W-1:0]    len_eff, bits_left;
    logic                sclk_q, ss_n_q, oe_q, done_q;
    logic [MAX_BITS-1:0] rx_q, rx_sh;
    logic                mosi_bit;
    logic                load, at_zero, rise_ev, fall_ev;

    // Clamp the requested length into the supported range
    always_comb begin
        if (word_len < LEN_W'(MIN_BITS))
            len_eff = LEN_W'(MIN_BITS);
        else if (word_len > LEN_W'(MAX_BITS))
            len_eff = LEN_W'(MAX_BITS);
        else
            len_eff = word_len;
    end

    // Event decode: load, rising edge due, falling edge with bits remaining
    always_comb begin
        div_sel = (state == ST_IDLE) ? div : div_q;
        load    = (state == ST_IDLE) && start;
        at_zero = (cnt == '0);
        rise_ev = ((state == ST_LEAD) || (state == ST_LOW)) && at_zero;
        fall_ev = (state == ST_HIGH) && at_zero && (bits_left != '0);
    end

    spi_phase_calc #(.DIV_W(DIV_W)) u_phase (
        .div        (div_sel),
        .period_len (per_len),
        .high_len   (hi_len),
        .low_len    (lo_len)
    );

    spi_shift_unit #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .tx_word   (tx_word),
        .len       (len_eff),
        .shift_ev  (fall_ev),
        .sample_ev (rise_ev),
        .miso      (miso),
        .mosi_bit  (mosi_bit),
        .rx_bits   (rx_sh)
    );

    // Transfer sequencer: phase counting, pin registers and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            bits_left <= '0;
            div_q     <= '0;
            sclk_q    <= 1'b0;
            ss_n_q    <= 1'b1;
            oe_q      <= 1'b0;
            done_q    <= 1'b0;
            rx_q      <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state     <= ST_LEAD;
                        cnt       <= per_len - CNT_W'(1);
                        div_q     <= div;
                        bits_left <= len_eff - LEN_W'(1);
                        ss_n_q    <= 1'b0;
                        oe_q      <= 1'b1;
                    end
                end
                ST_LEAD, ST_LOW: begin
                    if (at_zero) begin
                        state  <= ST_HIGH;
                        cnt    <= hi_len - CNT_W'(1);
                        sclk_q <= 1'b1;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_HIGH: begin
                    if (at_zero) begin
                        sclk_q <= 1'b0;
                        if (bits_left == '0) begin
                            state  <= ST_IDLE;
                            ss_n_q <= 1'b1;
                            oe_q   <= 1'b0;
                            done_q <= 1'b1;
                            rx_q   <= rx_sh;
                        end else begin
                            state     <= ST_LOW;
                            cnt       <= lo_len - CNT_W'(1);
                            bits_left <= bits_left - LEN_W'(1);
                        end
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state != ST_IDLE);
    assign done    = done_q;
    assign rx_word = rx_q;
    assign sclk    = sclk_q;
    assign ss_n    = ss_n_q;
    assign mosi_oe = oe_q;
    assign mosi    = oe_q & mosi_bit;

    // R1: busy tracks the select line
    p_busy_ss_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy == !ss_n);
    // R5: clock rests low while deselected
    p_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n |-> !sclk);
    // R5: clock rises only while selected
    p_rise_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> !ss_n);
    // R8: driver enable matches select
    p_oe_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mosi_oe == !ss_n);
    // R6: data holds except where the clock has just fallen
    p_mosi_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_n && !$past(ss_n) && !$fell(sclk)) |-> $stable(mosi));
    // R9: done accompanies the rise of select
    p_done_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_n) |-> done);
    // R9: done lasts one cycle
    p_done_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/spi_word_master_bench.sv
module spi_word_master_bench;
    localparam int MB = 32;
    localparam int DW = 8;
    localparam int LW = $clog2(MB + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [MB-1:0] tx_word = '0;
    logic [LW-1:0] word_len = LW'(8);
    logic [DW-1:0] div = '0;
    logic          busy, done, sclk, ss_n, mosi, mosi_oe;
    logic          miso = 1'b0;
    logic [MB-1:0] rx_word;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    spi_word_master #(.MAX_BITS(MB), .DIV_W(DW)) u_spi_word_master (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
        .word_len(word_len), .div(div), .busy(busy), .done(done),
        .rx_word(rx_word), .sclk(sclk), .ss_n(ss_n), .mosi(mosi),
        .mosi_oe(mosi_oe), .miso(miso)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One transfer, starting at the present negedge sample time
    task automatic run(input int dv, input int ln_in, input logic [31:0] txw,
                       input logic [31:0] slw, input bit ign, input string first_req);
        int ln, d, pp, hh, ll, t, last_rise, last_fall, rises, first_gap, idx;
        int bad_per, bad_hi, bad_lo, bad_oe, end_gap;
        bit prev, fin;
        logic [31:0] mask, cap;
        ln = (ln_in < 4) ? 4 : ((ln_in > MB) ? MB : ln_in);
        d  = (dv == 0) ? 1 : dv;
        pp = d + 1;
        hh = (d % 2 == 1) ? pp / 2 : d / 2 + 1;
        ll = pp - hh;
        mask = (ln == 32) ? 32'hFFFF_FFFF : ((32'd1 << ln) - 32'd1);
        div = DW'(dv); word_len = LW'(ln_in); tx_word = txw; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 1; prev = 1'b0; fin = 1'b0; rises = 0; first_gap = -1;
        last_rise = 0; last_fall = 0; cap = '0; end_gap = -1;
        bad_per = 0; bad_hi = 0; bad_lo = 0; bad_oe = 0;
        chk(ss_n == 1'b0 && busy == 1'b1, first_req, {ss_n, busy}, 2'b01);
        idx = ln - 1;
        miso = slw[idx];
        while (!fin && t < 20000) begin
            if (mosi_oe != !ss_n) bad_oe++;
            if (ss_n) begin
                fin = 1'b1;
                end_gap = t - last_rise;
            end else if (sclk && !prev) begin
                rises++;
                cap = {cap[30:0], mosi};
                if (rises == 1) first_gap = t - 1;
                else if (t - last_rise != pp) bad_per++;
                if (rises > 1 && t - last_fall != ll) bad_lo++;
                last_rise = t;
                if (ign && rises == 2) begin
                    start = 1'b1; tx_word = ~txw; div = DW'(dv + 3); word_len = LW'(5);
                end
            end else if (!sclk && prev) begin
                if (t - last_rise != hh) bad_hi++;
                last_fall = t;
                idx--;
                if (idx >= 0) miso = slw[idx];
            end
            prev = sclk;
            if (!fin) begin
                @(negedge clk);
                start = 1'b0;
                t++;
            end
        end
        chk(fin, "R1 transfer ended", fin, 1);
        chk(first_gap == pp, "R2 lead-in", first_gap, pp);
        chk(bad_per == 0, "R3 period", bad_per, 0);
        chk(bad_hi == 0 && bad_lo == 0, "R4 high/low split", {bad_hi, bad_lo}, 0);
        chk(rises == ln, "R6 edge count", rises, ln);
        chk(cap == (txw & mask), ign ? "R1 start ignored, word" : "R6 mosi word", cap, txw & mask);
        chk(rx_word == MB'(slw & mask), "R7 rx word", rx_word, slw & mask);
        chk(end_gap == hh && sclk == 1'b0, "R8 select release", end_gap, hh);
        chk(bad_oe == 0, "R8 output enable", bad_oe, 0);
        chk(done == 1'b1 && busy == 1'b0, "R9 done strobe", {done, busy}, 2'b10);
    endtask

    task automatic idle_gap();
        @(negedge clk);
        chk(done == 1'b0 && ss_n == 1'b1 && sclk == 1'b0, "R9 done single / R5 idle", {done, ss_n, sclk}, 3'b010);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hang expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int k;
        int lens[4] = '{4, 5, 8, 32};
        repeat (3) @(negedge clk);
        chk(ss_n == 1'b1 && sclk == 1'b0 && busy == 1'b0 && done == 1'b0 && mosi_oe == 1'b0,
            "R5 reset state", {ss_n, sclk, busy, done, mosi_oe}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        k = 0;
        for (int dv = 0; dv <= 6; dv++) begin
            for (int li = 0; li < 4; li++) begin
                run(dv, lens[li], 32'h9E37_79B9 * (k + 1), 32'h7F4A_7C15 * (k + 3), 1'b0, "R2 select falls");
                idle_gap();
                k++;
            end
        end
        // R10 clamp below and above range
        run(3, 2, 32'hFFFF_FFF5, 32'h0000_000A, 1'b0, "R10 short length");
        idle_gap();
        run(0, 0, 32'h1234_5679, 32'h8765_4321, 1'b0, "R10 zero length");
        idle_gap();
        run(2, 40, 32'hC0FF_EE01, 32'hDEAD_BEEF, 1'b0, "R10 long length");
        idle_gap();
        // R1 start while busy has no effect
        run(4, 8, 32'h0000_00B6, 32'h0000_005A, 1'b1, "R1 accepted start");
        idle_gap();
        // R11 restart in the done cycle
        run(1, 6, 32'h0000_002D, 32'h0000_0013, 1'b0, "R2 first of pair");
        run(5, 9, 32'h0000_01A7, 32'h0000_0159, 1'b0, "R11 restart in done cycle");
        run(6, 12, 32'h0000_0ACE, 32'h0000_0531, 1'b0, "R11 second restart");
        idle_gap();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule